// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a four-bit synchronous up counter meant to be chained into wider counters. Every change of state happens on the rising clock edge. An active-low clear forces the count to zero. An active-low preset copies a parallel input word into the count. When neither is asserted, the count advances by one, but only if both count enables are high. If either enable is low, the count holds. Clear wins over preset, and preset wins over counting.

The block has a carry output for cascading. It is high when the count is all ones and the chain enable is high. The free-running count enable has no effect on the carry. The carry is a combinational function of the stored count and the chain enable. A downstream stage can therefore take it as its chain enable in the same cycle, so a chain of stages advances on one common edge.

Top module: `presettable_counter4`

## Requirements
- R1: When `clear_n` is low at a rising edge, `count` becomes 0 after that edge, whatever the other inputs are.
- R2: When `preset_n` is low and `clear_n` is high at a rising edge, `count` takes the value of `preset_val` after that edge. The enables do not affect this.
- R3: When `clear_n` and `preset_n` are high and both `en_count` and `en_chain` are high at a rising edge, `count` increases by one.
- R4: When `clear_n` and `preset_n` are high and either enable is low at a rising edge, `count` keeps its value.
- R5: `carry_out` is high exactly when `en_chain` is high and `count` equals 15. It does not depend on `en_count`.
- R6: The priority order is clear, then preset, then counting. A clear that coincides with a preset yields 0.
- R7: Counting from 15 gives 0 on the next counting edge. A preset of 15 followed by one counting edge gives 0, and `carry_out` is high during the cycle in which the count is 15.
- R8: With both enables held high and clear and preset inactive, `count` steps through 0 to 15 in ascending order and then wraps.
- R9: Two stages, with the upper stage's `en_chain` driven by the lower stage's `carry_out`, count as one eight-bit counter.
- R10: `preset_val` is sampled only at clock edges. Changing it between edges leaves `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous clear, active low |
| preset_n | input | 1 | Synchronous parallel preset, active low |
| preset_val | input | 4 | Word loaded on a preset |
| en_count | input | 1 | Count enable that does not gate the carry |
| en_chain | input | 1 | Count enable that also qualifies the carry |
| count | output | 4 | Current count |
| carry_out | output | 1 | Terminal-count carry for the next stage |

## Verification
The bench looks for priority mistakes. It asserts clear together with preset and expects 0; a design that ranked preset above clear would show the loaded word. It separates the two enables: a carry that followed `en_count`, or that ignored `en_chain`, shows up at count 15. It also checks the wrap from 15 to 0 and the cascaded pair, where a carry that arrived one cycle late would make the upper stage miss or double a step. Finally, it moves `preset_val` between edges while preset is active, to catch a load that behaves like a latch.

// File: rtl/counter_pkg.sv
package counter_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2,
        OP_ZERO = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/cnt_op_sel.sv
module cnt_op_sel
    import counter_pkg::*;
(
    input  logic    clear_n,
    input  logic    preset_n,
    input  logic    en_count,
    input  logic    en_chain,
    output cnt_op_e op
);
    always_comb begin
        if (!clear_n)                  op = OP_ZERO;
        else if (!preset_n)            op = OP_LOAD;
        else if (en_count && en_chain) op = OP_STEP;
        else                           op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_toggle_net.sv
module cnt_toggle_net #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] toggle,
    output logic             all_ones
);
    assign toggle[0] = 1'b1;
    for (genvar i = 1; i < WIDTH; i++) begin : g_chain
        assign toggle[i] = toggle[i-1] & value[i-1];
    end
    assign all_ones = toggle[WIDTH-1] & value[WIDTH-1];
endmodule

// File: rtl/presettable_counter4.sv
module presettable_counter4
    import counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             preset_n,
    input  logic [WIDTH-1:0] preset_val,
    input  logic             en_count,
    input  logic             en_chain,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] value;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    cnt_op_e          op;
    logic [WIDTH-1:0] toggle;
    logic             all_ones;

    cnt_op_sel u_sel (
        .clear_n (clear_n),
        .preset_n(preset_n),
        .en_count(en_count),
        .en_chain(en_chain),
        .op      (op)
    );

    cnt_toggle_net #(.WIDTH(WIDTH)) u_tog (
        .value   (st_q.value),
        .toggle  (toggle),
        .all_ones(all_ones)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_ZERO: st_d.value = '0;
            OP_LOAD: st_d.value = preset_val;
            OP_STEP: st_d.value = st_q.value ^ toggle;
            default: st_d       = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count     = st_q.value;
    assign carry_out = en_chain & all_ones;

    // Assertion arming: becomes true after the first edge.
    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= 1'b1;

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!armed_q)
        !clear_n |=> count == '0);
    assert_preset_load_R2: assert property (@(posedge clk) disable iff (!armed_q)
        (clear_n && !preset_n) |=> count == $past(preset_val));
    assert_step_R3: assert property (@(posedge clk) disable iff (!armed_q)
        (clear_n && preset_n && en_count && en_chain) |=> count == $past(count) + ONE);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!armed_q)
        (clear_n && preset_n && !(en_count && en_chain)) |=> $stable(count));
    assert_carry_R5: assert property (@(posedge clk) disable iff (!armed_q)
        carry_out == (en_chain && count == {WIDTH{1'b1}}));
endmodule

// File: tb/presettable_counter4_test.sv
module presettable_counter4_test;
    logic       clk = 1'b0;
    logic       clear_n = 1'b1, preset_n = 1'b1, en_count = 1'b0, en_chain = 1'b0;
    logic [3:0] preset_val = 4'd0;
    logic [3:0] count, count_hi;
    logic       carry_out, carry_hi;
    int         total = 0, bad = 0;
    int         cycles = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    presettable_counter4 uut (
        .clk(clk), .clear_n(clear_n), .preset_n(preset_n), .preset_val(preset_val),
        .en_count(en_count), .en_chain(en_chain), .count(count), .carry_out(carry_out)
    );
    presettable_counter4 uut_hi (
        .clk(clk), .clear_n(clear_n), .preset_n(1'b1), .preset_val(4'd0),
        .en_count(1'b1), .en_chain(carry_out), .count(count_hi), .carry_out(carry_hi)
    );

    // {clear_n, preset_n, en_count, en_chain, val[3:0], exp_count[3:0], exp_carry, req[3:0]}
    localparam int NV = 15;
    localparam logic [16:0] VEC [NV] = '{
        {4'b0011, 4'd9,  4'd0,  1'b0, 4'd1},
        {4'b1011, 4'd5,  4'd5,  1'b0, 4'd2},
        {4'b1111, 4'd0,  4'd6,  1'b0, 4'd3},
        {4'b1101, 4'd0,  4'd6,  1'b0, 4'd4},
        {4'b1110, 4'd0,  4'd6,  1'b0, 4'd4},
        {4'b1000, 4'd14, 4'd14, 1'b0, 4'd2},
        {4'b1111, 4'd0,  4'd15, 1'b1, 4'd5},
        {4'b1101, 4'd0,  4'd15, 1'b1, 4'd5},
        {4'b1110, 4'd0,  4'd15, 1'b0, 4'd5},
        {4'b1111, 4'd0,  4'd0,  1'b0, 4'd7},
        {4'b0011, 4'd3,  4'd0,  1'b0, 4'd6},
        {4'b1011, 4'd10, 4'd10, 1'b0, 4'd2},
        {4'b1111, 4'd0,  4'd11, 1'b0, 4'd3},
        {4'b1011, 4'd15, 4'd15, 1'b1, 4'd7},
        {4'b1111, 4'd0,  4'd0,  1'b0, 4'd7}
    };

    function automatic string req_name(input int n);
        case (n)
            1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
            5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
            9: return "R9"; default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 5000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Table walk: drive at negedge, sample at following negedge.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check(req_name(int'(VEC[i-1][3:0])), count, VEC[i-1][8:5]);
                check(req_name(int'(VEC[i-1][3:0])), carry_out, VEC[i-1][4]);
            end
            {clear_n, preset_n, en_count, en_chain} = VEC[i][16:13];
            preset_val = VEC[i][12:9];
        end
        @(negedge clk);
        check(req_name(int'(VEC[NV-1][3:0])), count, VEC[NV-1][8:5]);
        check(req_name(int'(VEC[NV-1][3:0])), carry_out, VEC[NV-1][4]);

        // R5: carry ignores en_count, follows en_chain combinationally.
        preset_n = 1'b0; preset_val = 4'd15; en_count = 1'b0; en_chain = 1'b0;
        @(negedge clk); preset_n = 1'b1;
        #1 check("R5", carry_out, 0);
        en_chain = 1'b1; #1 check("R5", carry_out, 1);
        en_count = 1'b1; #1 check("R5", carry_out, 1);

        // R10: preset_val moves between edges, count unchanged until edge.
        en_count = 1'b0;
        @(negedge clk);
        preset_n = 1'b0; preset_val = 4'd2;
        #2 preset_val = 4'd7;
        #1 check("R10", count, 15);
        preset_val = 4'd4;
        @(negedge clk);
        check("R10", count, 4);
        preset_n = 1'b1;

        // R8: free-running sweep from 0 with wrap.
        clear_n = 1'b0;
        @(negedge clk);
        clear_n = 1'b1; en_count = 1'b1; en_chain = 1'b1;
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            check("R8", count, k % 16);
        end

        // R9: cascade of two stages behaves as eight-bit counter.
        clear_n = 1'b0;
        @(negedge clk);
        clear_n = 1'b1;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            check("R9", {count_hi, count}, k);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule